// File: doc/BRIEF.md
# Dual-Speed Serial Clock Phase Generator

This block produces the serial clock for a bus controller that runs each bit in one of three timing schemes: fast push-pull, slower open-drain, or legacy two-wire timing. Every bit is one low phase followed by one high phase. All lengths are counted in cycles of the functional clock. The push-pull period is the base unit. The open-drain low phase is a multiple of it, and each legacy phase is a multiple of the whole open-drain bit period. Besides the clock, the block emits a one-cycle strobe that tells the data path when to change SDA. In push-pull mode the strobe can be delayed from the falling clock edge, so the data line moves safely away from that edge.

A requester asks for bits by holding `bit_req` and asks for a stop sequence by holding `stop_req`. It drops the request in the cycle where the matching done pulse shows. A request that is still held at the end of a bit starts the next bit on the following edge, with no idle cycle between the two. Timing fields and the mode are captured when a bit starts. The stop sequence can be forced onto open-drain timing even when the data bits around it run push-pull.

Top module: `scl_timing_gen`

## Requirements
- R1: After reset, and while no request is pending, `scl` is 1 and `sda_strobe`, `bit_done` and `stop_done` are 0.
- R2: For a push-pull bit (`bit_mode`=0), the high phase lasts `pp_high_cfg`+1 cycles. `bit_done` is 1 only during the last high cycle.
- R3: For a push-pull bit, the low phase lasts (`pp_high_cfg`+1)+`pp_low_extra` cycles.
- R4: For an open-drain bit (`bit_mode`=1), the low phase lasts (`od_low_mult`+1)×(`pp_high_cfg`+1) cycles. The high phase lasts `pp_high_cfg`+1 cycles when `od_high_long`=0, and lasts the same as the open-drain low phase when `od_high_long`=1.
- R5: `sda_strobe` pulses once per low phase, always while `scl` is 0. In push-pull it comes in low cycle number `sda_skew`, counting the first low cycle as 0. In the other modes it comes in low cycle 0.
- R6: A push-pull `sda_skew` that is not below the low-phase length is clamped to that length minus one.
- R7: For a legacy bit (`bit_mode`=2), the low phase and the high phase each last (`i2c_div`+1)×(open-drain low + open-drain high) cycles.
- R8: A stop request produces one low and one high phase, and `stop_done` marks the last high cycle instead of `bit_done`. When `stop_open_drain`=1 and `bit_mode`=0, the stop uses open-drain lengths. Otherwise it uses the lengths of `bit_mode`.
- R9: The timing fields and `bit_mode` are sampled in the cycle a bit or stop starts. Changes made later in that bit have no effect until the next start.
- R10: While `en` is 0, `scl` is 1 and no strobe or done pulse appears. A bit in progress is abandoned at the next edge.
- R11: `bit_mode`=3 behaves exactly like open-drain mode.
- R12: When both requests are held at a start point, the stop starts first. A request held in the last high cycle starts the next bit or stop at the next edge, so `scl` falls with no idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Block enable |
| bit_req | input | 1 | Hold high to request bits |
| stop_req | input | 1 | Hold high to request a stop sequence |
| bit_mode | input | 2 | 0 push-pull, 1 open-drain, 2 legacy, 3 as open-drain |
| pp_high_cfg | input | BAUD_W | Push-pull high phase minus one |
| pp_low_extra | input | BAUD_W | Extra push-pull low cycles |
| od_low_mult | input | BAUD_W | Open-drain low length in push-pull periods, minus one |
| od_high_long | input | 1 | Open-drain high phase equals open-drain low phase |
| sda_skew | input | BAUD_W | Push-pull SDA strobe delay after SCL falls |
| i2c_div | input | I2C_W | Legacy phase length in open-drain bit periods, minus one |
| stop_open_drain | input | 1 | Force open-drain timing for the stop sequence |
| scl | output | 1 | Serial clock, 1 = released |
| sda_strobe | output | 1 | One-cycle SDA update strobe |
| bit_done | output | 1 | Last high cycle of a bit |
| stop_done | output | 1 | Last high cycle of a stop sequence |

## Verification
The bench uses the default field widths (four-bit timing fields, four-bit legacy divider). It drives small field values so that open-drain and legacy bits stay tens of cycles long. With these widths it can set a skew larger than a one-cycle low phase, which exercises the clamp. It can also set a multiplier of zero, where the open-drain low phase equals the push-pull period. A behavioural model tracks every cycle, so any phase that is one cycle too long or too short shows up at once. This covers configuration changes in the middle of a bit, enable drop-outs and the case where both requests collide.

// File: rtl/scl_tg_pkg.sv
package scl_tg_pkg;

  typedef enum logic [1:0] {
    MODE_PP  = 2'd0,
    MODE_OD  = 2'd1,
    MODE_LEG = 2'd2,
    MODE_RSV = 2'd3
  } scl_mode_e;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_HIGH = 2'd2
  } phase_e;

  // Counter width able to hold the longest legacy phase
  function automatic int len_width(input int baud_w, input int div_w);
    return 2 * baud_w + div_w + 3;
  endfunction

endpackage

// File: rtl/scl_tg_len_calc.sv
module scl_tg_len_calc
  import scl_tg_pkg::*;
#(
  parameter int BAUD_W = 4,
  parameter int I2C_W  = 4,
  parameter int LEN_W  = 15
) (
  input  logic [1:0]        bit_mode,
  input  logic              is_stop,
  input  logic              stop_open_drain,
  input  logic [BAUD_W-1:0] pp_high_cfg,
  input  logic [BAUD_W-1:0] pp_low_extra,
  input  logic [BAUD_W-1:0] od_low_mult,
  input  logic              od_high_long,
  input  logic [BAUD_W-1:0] sda_skew,
  input  logic [I2C_W-1:0]  i2c_div,
  output logic [LEN_W-1:0]  low_len,
  output logic [LEN_W-1:0]  high_len,
  output logic [LEN_W-1:0]  skew_len
);

  localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

  logic [LEN_W-1:0] pp_hi, pp_lo, od_lo, od_hi, od_bit, leg_ph, skew_raw, pp_skew;
  scl_mode_e        eff_mode;

  // Base lengths, one chain of products from the push-pull unit upward
  always_comb begin
    pp_hi    = LEN_W'(pp_high_cfg) + ONE;
    pp_lo    = pp_hi + LEN_W'(pp_low_extra);
    od_lo    = (LEN_W'(od_low_mult) + ONE) * pp_hi;
    od_hi    = od_high_long ? od_lo : pp_hi;
    od_bit   = od_lo + od_hi;
    leg_ph   = (LEN_W'(i2c_div) + ONE) * od_bit;
    skew_raw = LEN_W'(sda_skew);
    pp_skew  = (skew_raw >= pp_lo) ? (pp_lo - ONE) : skew_raw;
  end

  // Effective mode: reserved code folds onto open-drain, stop may be forced
  always_comb begin
    eff_mode = scl_mode_e'(bit_mode);
    if (eff_mode == MODE_RSV) eff_mode = MODE_OD;
    if (is_stop && stop_open_drain && (eff_mode == MODE_PP)) eff_mode = MODE_OD;
  end

  always_comb begin
    unique case (eff_mode)
      MODE_PP: begin
        low_len  = pp_lo;
        high_len = pp_hi;
        skew_len = pp_skew;
      end
      MODE_LEG: begin
        low_len  = leg_ph;
        high_len = leg_ph;
        skew_len = '0;
      end
      default: begin
        low_len  = od_lo;
        high_len = od_hi;
        skew_len = '0;
      end
    endcase
  end

endmodule

// File: rtl/scl_tg_phase_ctrl.sv
module scl_tg_phase_ctrl
  import scl_tg_pkg::*;
#(
  parameter int LEN_W = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             bit_req,
  input  logic             stop_req,
  input  logic [LEN_W-1:0] ld_low,
  input  logic [LEN_W-1:0] ld_high,
  input  logic [LEN_W-1:0] ld_skew,
  output phase_e           state_q,
  output logic [LEN_W-1:0] cnt_q,
  output logic [LEN_W-1:0] low_q,
  output logic [LEN_W-1:0] high_q,
  output logic [LEN_W-1:0] skew_q,
  output logic             stop_q
);

  localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

  phase_e           state_d;
  logic [LEN_W-1:0] cnt_d;
  logic             stop_d;
  logic             load;
  logic             any_req;
  logic             low_end;
  logic             high_end;

  assign any_req  = bit_req | stop_req;
  assign low_end  = (cnt_q == (low_q - ONE));
  assign high_end = (cnt_q == (high_q - ONE));

  // Next-state logic
  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    stop_d  = stop_q;
    load    = 1'b0;
    if (!en) begin
      state_d = PH_IDLE;
      cnt_d   = '0;
    end else begin
      unique case (state_q)
        PH_IDLE: begin
          if (any_req) load = 1'b1;
        end
        PH_LOW: begin
          if (low_end) begin
            state_d = PH_HIGH;
            cnt_d   = '0;
          end else begin
            cnt_d = cnt_q + ONE;
          end
        end
        PH_HIGH: begin
          if (high_end) begin
            if (any_req) begin
              load = 1'b1;
            end else begin
              state_d = PH_IDLE;
              cnt_d   = '0;
            end
          end else begin
            cnt_d = cnt_q + ONE;
          end
        end
        default: begin
          state_d = PH_IDLE;
          cnt_d   = '0;
        end
      endcase
    end
    if (load) begin
      state_d = PH_LOW;
      cnt_d   = '0;
      stop_d  = stop_req;
    end
  end

  // Phase state and counter
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PH_IDLE;
      cnt_q   <= '0;
      stop_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      stop_q  <= stop_d;
    end
  end

  // Per-bit timing snapshot, clock-enabled by the start decision
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_q  <= '0;
      high_q <= '0;
      skew_q <= '0;
    end else if (load) begin
      low_q  <= ld_low;
      high_q <= ld_high;
      skew_q <= ld_skew;
    end
  end

  AST_OFF_GOES_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (state_q == PH_IDLE)); // R10

  AST_LOW_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PH_LOW) |-> (cnt_q < low_q)); // R3

  AST_HIGH_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PH_HIGH) |-> (cnt_q < high_q)); // R2

  AST_SKEW_INSIDE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != PH_IDLE) |-> (skew_q < low_q)); // R6

  AST_SNAPSHOT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PH_LOW) |=> ($stable(low_q) && $stable(high_q) && $stable(skew_q))); // R9

endmodule

// File: rtl/scl_tg_out_dec.sv
module scl_tg_out_dec
  import scl_tg_pkg::*;
#(
  parameter int LEN_W = 15
) (
  input  logic             en,
  input  phase_e           state_q,
  input  logic [LEN_W-1:0] cnt_q,
  input  logic [LEN_W-1:0] high_q,
  input  logic [LEN_W-1:0] skew_q,
  input  logic             stop_q,
  output logic             scl,
  output logic             sda_strobe,
  output logic             bit_done,
  output logic             stop_done
);

  logic in_low, last_high;

  always_comb begin
    in_low     = en && (state_q == PH_LOW);
    last_high  = en && (state_q == PH_HIGH) && (cnt_q == (high_q - LEN_W'(1)));
    scl        = !in_low;
    sda_strobe = in_low && (cnt_q == skew_q);
    bit_done   = last_high && !stop_q;
    stop_done  = last_high && stop_q;
  end

endmodule

// File: rtl/scl_timing_gen.sv
module scl_timing_gen
  import scl_tg_pkg::*;
#(
  parameter int BAUD_W = 4,
  parameter int I2C_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              bit_req,
  input  logic              stop_req,
  input  logic [1:0]        bit_mode,
  input  logic [BAUD_W-1:0] pp_high_cfg,
  input  logic [BAUD_W-1:0] pp_low_extra,
  input  logic [BAUD_W-1:0] od_low_mult,
  input  logic              od_high_long,
  input  logic [BAUD_W-1:0] sda_skew,
  input  logic [I2C_W-1:0]  i2c_div,
  input  logic              stop_open_drain,
  output logic              scl,
  output logic              sda_strobe,
  output logic              bit_done,
  output logic              stop_done
);

  localparam int LEN_W = len_width(BAUD_W, I2C_W);

  logic [LEN_W-1:0] ld_low, ld_high, ld_skew;
  logic [LEN_W-1:0] cnt_q, low_q, high_q, skew_q;
  logic             stop_q;
  phase_e           state_q;

  scl_tg_len_calc #(
    .BAUD_W(BAUD_W),
    .I2C_W (I2C_W),
    .LEN_W (LEN_W)
  ) u_len (
    .bit_mode       (bit_mode),
    .is_stop        (stop_req),
    .stop_open_drain(stop_open_drain),
    .pp_high_cfg    (pp_high_cfg),
    .pp_low_extra   (pp_low_extra),
    .od_low_mult    (od_low_mult),
    .od_high_long   (od_high_long),
    .sda_skew       (sda_skew),
    .i2c_div        (i2c_div),
    .low_len        (ld_low),
    .high_len       (ld_high),
    .skew_len       (ld_skew)
  );

  scl_tg_phase_ctrl #(
    .LEN_W(LEN_W)
  ) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (en),
    .bit_req (bit_req),
    .stop_req(stop_req),
    .ld_low  (ld_low),
    .ld_high (ld_high),
    .ld_skew (ld_skew),
    .state_q (state_q),
    .cnt_q   (cnt_q),
    .low_q   (low_q),
    .high_q  (high_q),
    .skew_q  (skew_q),
    .stop_q  (stop_q)
  );

  scl_tg_out_dec #(
    .LEN_W(LEN_W)
  ) u_dec (
    .en        (en),
    .state_q   (state_q),
    .cnt_q     (cnt_q),
    .high_q    (high_q),
    .skew_q    (skew_q),
    .stop_q    (stop_q),
    .scl       (scl),
    .sda_strobe(sda_strobe),
    .bit_done  (bit_done),
    .stop_done (stop_done)
  );

  AST_STROBE_WHILE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    sda_strobe |-> !scl); // R5

  AST_DONE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(bit_done && stop_done)); // R8

  AST_DONE_ONLY_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_done || stop_done) |-> scl); // R2

  AST_SCL_FALLS_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    ((bit_done || stop_done) && (bit_req || stop_req) && en) |=> (!scl || !en)); // R12

endmodule

// File: tb/scl_timing_gen_bench.sv
module scl_timing_gen_bench;

  localparam int CLK_PERIOD = 10;
  localparam int BW = 4;
  localparam int DW = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          en, bit_req, stop_req;
  logic [1:0]    bit_mode;
  logic [BW-1:0] pp_high_cfg, pp_low_extra, od_low_mult, sda_skew;
  logic          od_high_long, stop_open_drain;
  logic [DW-1:0] i2c_div;
  logic          scl, sda_strobe, bit_done, stop_done;

  int    n_checks = 0;
  int    n_fail   = 0;
  int    cyc      = 0;
  bit    comparing = 1'b0;
  bit    finished  = 1'b0;
  string cur_req  = "R1";

  // reference model state
  int m_ph = 0;
  int m_cnt = 0;
  int m_lo = 0;
  int m_hi = 0;
  int m_sk = 0;
  bit m_stop = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  scl_timing_gen #(.BAUD_W(BW), .I2C_W(DW)) u_scl_timing_gen (
    .clk(clk), .rst_n(rst_n), .en(en), .bit_req(bit_req), .stop_req(stop_req),
    .bit_mode(bit_mode), .pp_high_cfg(pp_high_cfg), .pp_low_extra(pp_low_extra),
    .od_low_mult(od_low_mult), .od_high_long(od_high_long), .sda_skew(sda_skew),
    .i2c_div(i2c_div), .stop_open_drain(stop_open_drain),
    .scl(scl), .sda_strobe(sda_strobe), .bit_done(bit_done), .stop_done(stop_done)
  );

  // Phase lengths computed straight from the requirements
  task automatic m_load(input bit is_stop);
    int ph, pl, ol, oh, lg, md;
    ph = int'(pp_high_cfg) + 1;                       // R2
    pl = ph + int'(pp_low_extra);                     // R3
    ol = (int'(od_low_mult) + 1) * ph;                // R4
    oh = od_high_long ? ol : ph;                      // R4
    lg = (int'(i2c_div) + 1) * (ol + oh);             // R7
    md = int'(bit_mode);
    if (md == 3) md = 1;                              // R11
    if (is_stop && stop_open_drain && md == 0) md = 1; // R8
    if (md == 0) begin
      m_lo = pl; m_hi = ph;
      m_sk = (int'(sda_skew) > pl - 1) ? pl - 1 : int'(sda_skew); // R5 R6
    end else if (md == 2) begin
      m_lo = lg; m_hi = lg; m_sk = 0;
    end else begin
      m_lo = ol; m_hi = oh; m_sk = 0;
    end
    m_stop = is_stop;
    m_ph = 1;
    m_cnt = 0;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ph = 0; m_cnt = 0; m_stop = 1'b0;
    end else if (!en) begin
      m_ph = 0; m_cnt = 0;
    end else if (m_ph == 0) begin
      if (stop_req) m_load(1'b1);
      else if (bit_req) m_load(1'b0);
    end else if (m_ph == 1) begin
      if (m_cnt == m_lo - 1) begin m_ph = 2; m_cnt = 0; end
      else m_cnt++;
    end else begin
      if (m_cnt == m_hi - 1) begin
        if (stop_req) m_load(1'b1);
        else if (bit_req) m_load(1'b0);
        else begin m_ph = 0; m_cnt = 0; end
      end else m_cnt++;
    end
  end

  // Per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    bit e_scl, e_str, e_bd, e_sd;
    #2;
    if (comparing && rst_n && !finished) begin
      e_scl = !(en && m_ph == 1);
      e_str = en && m_ph == 1 && m_cnt == m_sk;
      e_bd  = en && m_ph == 2 && !m_stop && m_cnt == m_hi - 1;
      e_sd  = en && m_ph == 2 && m_stop && m_cnt == m_hi - 1;
      n_checks++;
      if ({scl, sda_strobe, bit_done, stop_done} !== {e_scl, e_str, e_bd, e_sd}) begin
        n_fail++;
        $display("FAIL %s cyc=%0d scl/strobe/bdone/sdone actual=%b%b%b%b expected=%b%b%b%b",
                 cur_req, cyc, scl, sda_strobe, bit_done, stop_done, e_scl, e_str, e_bd, e_sd);
      end
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      summary();
    end
  end

  // Hold bit_req until n bit_done pulses seen; returns count of scl falls seen
  task automatic run_bits(input int n, output int falls);
    int got;
    bit prev;
    got = 0; falls = 0; prev = scl;
    bit_req = 1'b1;
    while (got < n) begin
      @(negedge clk); #1;
      if (prev && !scl) falls++;
      prev = scl;
      if (bit_done) got++;
    end
    bit_req = 1'b0;
  endtask

  task automatic run_stop();
    stop_req = 1'b1;
    do begin @(negedge clk); #1; end while (!stop_done);
    stop_req = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_cfg(input int mode, input int ph, input int add, input int om,
                         input bit hl, input int sk, input int dv);
    bit_mode = 2'(mode); pp_high_cfg = BW'(ph); pp_low_extra = BW'(add);
    od_low_mult = BW'(om); od_high_long = hl; sda_skew = BW'(sk); i2c_div = DW'(dv);
  endtask

  initial begin
    int falls, low_run, first_done;
    rst_n = 1'b0; en = 1'b0; bit_req = 1'b0; stop_req = 1'b0; stop_open_drain = 1'b0;
    set_cfg(0, 2, 3, 1, 1'b0, 2, 0);
    idle(3);
    // R1: reset state
    check("R1 scl in reset", int'(scl), 1);
    check("R1 strobes in reset", int'({sda_strobe, bit_done, stop_done}), 0);
    @(negedge clk); rst_n = 1'b1; en = 1'b1; comparing = 1'b1;
    idle(4);
    cur_req = "R1"; check("R1 scl idle", int'(scl), 1);

    // R2 R3 R5: push-pull, back-to-back bits (R12)
    cur_req = "R2 R3 R5 R12 push-pull";
    run_bits(4, falls);
    check("R12 back-to-back falls", falls, 4);
    idle(3);

    // R3: measured low run with extra cycles
    set_cfg(0, 1, 4, 0, 1'b0, 1, 0);
    cur_req = "R3 low length";
    bit_req = 1'b1; low_run = 0;
    do begin @(negedge clk); #1; if (!scl) low_run++; end while (!bit_done);
    bit_req = 1'b0;
    check("R3 measured low run", low_run, 2 + 4);
    idle(2);

    // R6: skew clamp
    set_cfg(0, 0, 0, 0, 1'b0, 9, 0);
    cur_req = "R6 skew clamp";
    run_bits(3, falls);
    set_cfg(0, 0, 2, 0, 1'b0, 15, 0);
    run_bits(2, falls);
    idle(2);

    // R4: open-drain, short and long high
    set_cfg(1, 1, 5, 2, 1'b0, 3, 0);
    cur_req = "R4 open-drain short high";
    run_bits(2, falls);
    od_high_long = 1'b1;
    cur_req = "R4 open-drain long high";
    run_bits(2, falls);
    set_cfg(1, 3, 0, 0, 1'b0, 0, 0);
    cur_req = "R4 open-drain unit multiplier";
    run_bits(1, falls);
    idle(2);

    // R11: reserved mode code
    set_cfg(3, 1, 2, 1, 1'b1, 2, 0);
    cur_req = "R11 mode 3";
    run_bits(2, falls);
    idle(2);

    // R7: legacy timing
    set_cfg(2, 0, 3, 0, 1'b0, 2, 1);
    cur_req = "R7 legacy";
    run_bits(2, falls);
    set_cfg(2, 1, 0, 1, 1'b1, 0, 0);
    run_bits(1, falls);
    idle(2);

    // R8: stop with and without forced open-drain
    set_cfg(0, 1, 1, 2, 1'b0, 1, 0);
    stop_open_drain = 1'b1;
    cur_req = "R8 forced open-drain stop";
    run_bits(1, falls);
    run_stop();
    stop_open_drain = 1'b0;
    cur_req = "R8 push-pull stop";
    run_stop();
    idle(2);

    // R9: configuration change in the middle of a bit
    set_cfg(0, 3, 2, 0, 1'b0, 2, 0);
    cur_req = "R9 mid-bit change";
    bit_req = 1'b1;
    idle(3);
    pp_high_cfg = 4'd0; pp_low_extra = 4'd0; bit_mode = 2'd1; sda_skew = 4'd0;
    do begin @(negedge clk); #1; end while (!bit_done);
    @(negedge clk); #1;
    bit_req = 1'b0;
    do begin @(negedge clk); #1; end while (!bit_done);
    idle(2);

    // R10: enable drop mid-bit
    set_cfg(0, 2, 2, 0, 1'b0, 1, 0);
    cur_req = "R10 enable off";
    bit_req = 1'b1;
    idle(3);
    en = 1'b0;
    for (int i = 0; i < 5; i++) begin
      #3;
      check("R10 scl while off", int'(scl), 1);
      check("R10 pulses while off", int'({sda_strobe, bit_done, stop_done}), 0);
      @(negedge clk);
    end
    en = 1'b1;
    do begin @(negedge clk); #1; end while (!bit_done);
    bit_req = 1'b0;
    idle(3);

    // R12: stop wins over bit when both held
    cur_req = "R12 priority";
    stop_req = 1'b1; bit_req = 1'b1; first_done = 0;
    do begin
      @(negedge clk); #1;
      if (bit_done && first_done == 0) first_done = 1;
      if (stop_done && first_done == 0) first_done = 2;
    end while (first_done == 0);
    stop_req = 1'b0;
    check("R12 stop first", first_done, 2);
    do begin @(negedge clk); #1; end while (!bit_done);
    bit_req = 1'b0;
    idle(4);
    cur_req = "R1";
    check("R1 scl after traffic", int'(scl), 1);

    comparing = 1'b0;
    summary();
  end

endmodule